// File: doc/BRIEF.md
# Duty Ratio Search Engine

This block searches for the pair of 8-bit OFF and ON counts whose ratio best
approximates a requested frequency as a fraction of a stock frequency, both
given in kHz. The OFF count is the share of a modulation period during which
the clock runs, and the ON count is the share during which it is held. The
frequency that results is the stock frequency scaled by OFF / (OFF + ON).

A start pulse latches the target, the stock frequency and a maximum total
duration. The engine then walks the total duration from that maximum down to 1.
For each length it derives a candidate OFF count and the frequency that
candidate really gives, using one shared bit-serial divider for both
quotients. It keeps the best candidate, and on equal error it prefers the
later and therefore shorter period. A one-cycle done pulse marks the end. The
chosen counts and the achieved frequency stay on the outputs until the next
accepted start.

Top module: `duty_search`

## Requirements
- R1: After reset, done, busy and err are 0, off_cnt is 1, on_cnt is 0 and freq_khz is 0.
- R2: A start seen while the engine is idle latches target_khz, stock_khz and max_dur, and busy is 1 from the next cycle until the search ends. A start seen while busy is ignored and does not change the result.
- R3: A max_dur above 255 is treated as 255.
- R4: For every total duration i from the clamped maximum D down to 1, the candidate OFF count is floor(target*i/stock) modulo 256. The candidate ON count is (i - OFF) modulo 256. The candidate frequency is floor(stock*OFF/i).
- R5: A candidate replaces the held result when |candidate frequency - target| is less than or equal to the held error. Equal error therefore goes to the smaller i.
- R6: Before the first candidate, the held result is OFF=1, ON=0, frequency=stock.
- R7: With D = 0 and a nonzero stock, done is 1 in the cycle after the start, with err 0 and the R6 result.
- R8: With stock_khz = 0, done and err are both 1 in the cycle after the start, with OFF=1, ON=0 and frequency 0.
- R9: done lasts one cycle. off_cnt, on_cnt, freq_khz and err hold their values until the next accepted start, and that start clears err.
- R10: A start in the same cycle as done is accepted and begins a new search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse that begins a search |
| target_khz | input | 32 | Requested frequency in kHz |
| stock_khz | input | 32 | Unmodulated frequency in kHz, must be nonzero |
| max_dur | input | 16 | Upper bound of the total duration, clamped to 255 |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse at the end of a search |
| err | output | 1 | Last accepted request had a zero stock frequency |
| off_cnt | output | 8 | Chosen OFF count |
| on_cnt | output | 8 | Chosen ON count |
| freq_khz | output | 40 | Frequency reached by the chosen counts |

## Verification
The done pulse and the acceptance of a new request can fall in the same cycle,
because the engine is already idle while done is high. The bench provokes this
by raising start at the very falling edge where it first sees done. It first
judges the finished result on the outputs in that cycle. It then requires busy
in the following cycle and a second result that matches the arithmetic model
for the new inputs. A start pulse sent in the middle of a search is also
checked, against the model for the original inputs only.

// File: rtl/duty_pkg.sv
package duty_pkg;

    localparam int FREQ_W   = 32;
    localparam int CNT_W    = 8;
    localparam int PROD_W   = FREQ_W + CNT_W;
    localparam int DUR_IN_W = 16;
    localparam int DUR_MAX  = (1 << CNT_W) - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFF_GO,
        ST_OFF_WAIT,
        ST_FRQ_GO,
        ST_FRQ_WAIT
    } state_e;

    typedef struct packed {
        logic [CNT_W-1:0]  off;
        logic [CNT_W-1:0]  on;
        logic [PROD_W-1:0] freq;
    } ratio_t;

    function automatic logic [PROD_W-1:0] abs_gap(input logic [PROD_W-1:0] a,
                                                  input logic [PROD_W-1:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    function automatic logic [CNT_W-1:0] clamp_dur(input logic [DUR_IN_W-1:0] d);
        return (d > DUR_IN_W'(DUR_MAX)) ? CNT_W'(DUR_MAX) : d[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/duty_div.sv
module duty_div #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         valid
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  dvs_q, quo_q, rem_q, dvd_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, valid_q;
    logic [W:0]    shifted, diff;
    logic          fits;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, dvs_q};
        fits    = shifted >= {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvs_q   <= '0;
            quo_q   <= '0;
            rem_q   <= '0;
            dvd_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start) begin
                dvs_q <= divisor;
                quo_q <= dividend;
                dvd_q <= dividend;
                rem_q <= '0;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q   <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;
    assign valid    = valid_q;

    // R4: each quotient handed out is exact
    a_r4_div_exact: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> ((2*W)'(quo_q) * (2*W)'(dvs_q) + (2*W)'(rem_q)) == (2*W)'(dvd_q));

    a_r4_rem_below: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> rem_q < dvs_q);

endmodule

// File: rtl/duty_best.sv
module duty_best
    import duty_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic [FREQ_W-1:0] init_stock,
    input  logic [FREQ_W-1:0] target,
    input  logic              upd,
    input  ratio_t            cand,
    output ratio_t            best
);
    ratio_t            best_q;
    logic [PROD_W-1:0] gap_q, cand_gap;

    always_comb cand_gap = abs_gap(cand.freq, PROD_W'(target));

    always_ff @(posedge clk) begin
        if (rst) begin
            best_q.off  <= CNT_W'(1);
            best_q.on   <= '0;
            best_q.freq <= '0;
            gap_q       <= '0;
        end else if (init) begin
            best_q.off  <= CNT_W'(1);
            best_q.on   <= '0;
            best_q.freq <= PROD_W'(init_stock);
            gap_q       <= abs_gap(PROD_W'(init_stock), PROD_W'(target));
        end else if (upd && (cand_gap <= gap_q)) begin
            best_q <= cand;
            gap_q  <= cand_gap;
        end
    end

    assign best = best_q;

    // R5: the held error never grows during a search
    a_r5_gap_never_grows: assert property (@(posedge clk) disable iff (rst)
        upd |=> gap_q <= $past(gap_q));

    // R5: an equal error takes the newer candidate
    a_r5_tie_taken: assert property (@(posedge clk) disable iff (rst)
        (upd && !init && cand_gap == gap_q) |=> best_q == $past(cand));

endmodule

// File: rtl/duty_search.sv
module duty_search
    import duty_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [FREQ_W-1:0]   target_khz,
    input  logic [FREQ_W-1:0]   stock_khz,
    input  logic [DUR_IN_W-1:0] max_dur,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [CNT_W-1:0]    off_cnt,
    output logic [CNT_W-1:0]    on_cnt,
    output logic [PROD_W-1:0]   freq_khz
);
    state_e            state_q;
    logic [FREQ_W-1:0] tgt_q, stk_q;
    logic [CNT_W-1:0]  i_q, off_q, dur_c;
    logic              done_q, err_q, accept;
    logic              div_start, div_valid, upd;
    logic [PROD_W-1:0] div_dvd, div_dvs, div_quo;
    logic [FREQ_W-1:0] ref_target;
    ratio_t            cand, best;

    always_comb begin
        accept     = (state_q == ST_IDLE) && start;
        dur_c      = clamp_dur(max_dur);
        ref_target = accept ? target_khz : tgt_q;
        div_start  = (state_q == ST_OFF_GO) || (state_q == ST_FRQ_GO);
        if (state_q == ST_OFF_GO) begin
            div_dvd = PROD_W'(tgt_q) * PROD_W'(i_q);
            div_dvs = PROD_W'(stk_q);
        end else begin
            div_dvd = PROD_W'(stk_q) * PROD_W'(off_q);
            div_dvs = PROD_W'(i_q);
        end
        cand.off  = off_q;
        cand.on   = i_q - off_q;
        cand.freq = div_quo;
        upd       = (state_q == ST_FRQ_WAIT) && div_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
            stk_q   <= '0;
            i_q     <= '0;
            off_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        tgt_q <= target_khz;
                        stk_q <= stock_khz;
                        i_q   <= dur_c;
                        err_q <= 1'b0;
                        if (stock_khz == '0) begin
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                        end else if (dur_c == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_OFF_GO;
                        end
                    end
                end
                ST_OFF_GO:   state_q <= ST_OFF_WAIT;
                ST_OFF_WAIT: begin
                    if (div_valid) begin
                        off_q   <= div_quo[CNT_W-1:0];
                        state_q <= ST_FRQ_GO;
                    end
                end
                ST_FRQ_GO:   state_q <= ST_FRQ_WAIT;
                ST_FRQ_WAIT: begin
                    if (div_valid) begin
                        if (i_q == CNT_W'(1)) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            i_q     <= i_q - CNT_W'(1);
                            state_q <= ST_OFF_GO;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    duty_div #(.W(PROD_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (div_dvd),
        .divisor  (div_dvs),
        .quotient (div_quo),
        .valid    (div_valid)
    );

    duty_best u_best (
        .clk        (clk),
        .rst        (rst),
        .init       (accept),
        .init_stock (stock_khz),
        .target     (ref_target),
        .upd        (upd),
        .cand       (cand),
        .best       (best)
    );

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign off_cnt  = best.off;
    assign on_cnt   = best.on;
    assign freq_khz = best.freq;

    // R9: done is a single-cycle pulse unless a new request follows at once
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);

    // R9: outputs hold while idle with no request
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable({off_cnt, on_cnt, freq_khz, err}));

    // R8: err only rises together with done
    a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);

    // R4: the duration counter never reaches zero during a search
    a_r4_count_live: assert property (@(posedge clk) disable iff (rst)
        busy |-> i_q != '0);

    // R2: an accepted request with work to do makes the engine busy
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && stock_khz != '0 && max_dur != '0) |=> busy);

endmodule

// File: tb/duty_search_test.sv
module duty_search_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] target_khz = '0;
    logic [31:0] stock_khz = '0;
    logic [15:0] max_dur = '0;
    logic        busy, done, err;
    logic [7:0]  off_cnt, on_cnt;
    logic [39:0] freq_khz;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    duty_search uut (
        .clk(clk), .rst(rst), .start(start), .target_khz(target_khz),
        .stock_khz(stock_khz), .max_dur(max_dur), .busy(busy), .done(done),
        .err(err), .off_cnt(off_cnt), .on_cnt(on_cnt), .freq_khz(freq_khz)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint absl(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic void model(input longint t, input longint s, input longint d,
                                  output longint ro, output longint rn, output longint rf);
        longint dd;
        dd = (d > 255) ? 255 : d;
        ro = 1; rn = 0; rf = s;
        if (s == 0) return;
        for (longint i = dd; i >= 1; i--) begin
            longint o, n, f;
            o = ((t * i) / s) % 256;
            n = (i - o + 256) % 256;
            f = (s * o) / i;
            if (absl(f - t) <= absl(rf - t)) begin
                ro = o; rn = n; rf = f;
            end
        end
    endfunction

    task automatic launch(input longint t, input longint s, input longint d);
        @(negedge clk);
        target_khz = 32'(t);
        stock_khz  = 32'(s);
        max_dur    = 16'(d);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 40000) begin
            @(negedge clk);
            n++;
        end
        if (!done) chk({tag, " done never seen"}, 0, 1);
    endtask

    task automatic cmp_model(input string tag, input longint t, input longint s, input longint d);
        longint eo, en, ef;
        model(t, s, d, eo, en, ef);
        chk({tag, " off"}, off_cnt, eo);
        chk({tag, " on"}, on_cnt, en);
        chk({tag, " freq"}, freq_khz, ef);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        longint stocks[3];
        longint durs[6];
        stocks[0] = 97; stocks[1] = 1000; stocks[2] = 200000;
        durs[0] = 1; durs[1] = 2; durs[2] = 3; durs[3] = 5; durs[4] = 8; durs[5] = 12;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", done, 0);
        chk("R1 busy", busy, 0);
        chk("R1 err", err, 0);
        chk("R1 off", off_cnt, 1);
        chk("R1 on", on_cnt, 0);
        chk("R1 freq", freq_khz, 0);

        // R7 / R6: zero duration returns the initial result at once
        launch(500, 1000, 0);
        chk("R7 done", done, 1);
        chk("R7 busy", busy, 0);
        chk("R7 err", err, 0);
        chk("R6 off", off_cnt, 1);
        chk("R6 on", on_cnt, 0);
        chk("R6 freq", freq_khz, 1000);

        // R8: zero stock raises err with done
        launch(5, 0, 7);
        chk("R8 done", done, 1);
        chk("R8 err", err, 1);
        chk("R8 off", off_cnt, 1);
        chk("R8 freq", freq_khz, 0);
        repeat (3) @(negedge clk);
        chk("R9 err held", err, 1);
        chk("R9 done dropped", done, 0);

        // R5: tie between i=4 and i=2 goes to i=2
        launch(500, 1000, 4);
        chk("R9 err cleared by start", err, 0);
        wait_done("R5");
        chk("R5 tie off", off_cnt, 1);
        chk("R5 tie on", on_cnt, 1);
        chk("R5 tie freq", freq_khz, 500);

        // R9: outputs held after done
        repeat (4) @(negedge clk);
        chk("R9 done pulse", done, 0);
        chk("R9 hold off", off_cnt, 1);
        chk("R9 hold on", on_cnt, 1);
        chk("R9 hold freq", freq_khz, 500);

        // R3: max_dur 300 acts as 255; only i=255 hits the target exactly
        launch(1000, 255000, 300);
        wait_done("R3");
        chk("R3 off", off_cnt, 1);
        chk("R3 on", on_cnt, 254);
        chk("R3 freq", freq_khz, 1000);

        // R4: OFF truncated to 8 bits when target exceeds stock
        launch(500, 100, 60);
        wait_done("R4 trunc");
        cmp_model("R4 trunc", 500, 100, 60);

        // R2: a start during a search is ignored
        launch(300, 1000, 6);
        chk("R2 busy", busy, 1);
        @(negedge clk);
        target_khz = 999; stock_khz = 7; max_dur = 3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R2");
        cmp_model("R2 ignore", 300, 1000, 6);

        // R10: start in the done cycle is accepted
        target_khz = 250; stock_khz = 1000; max_dur = 5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 busy", busy, 1);
        wait_done("R10");
        cmp_model("R10 second", 250, 1000, 5);

        // R4 / R5 / R6 sweep against the arithmetic model
        for (int si = 0; si < 3; si++) begin
            for (int ti = 0; ti < 6; ti++) begin
                for (int di = 0; di < 6; di++) begin
                    longint s, t;
                    s = stocks[si];
                    case (ti)
                        0: t = 0;
                        1: t = s / 3;
                        2: t = s / 2;
                        3: t = s - 1;
                        4: t = s;
                        default: t = s + s / 4;
                    endcase
                    launch(t, s, durs[di]);
                    wait_done("R4 sweep");
                    cmp_model("R4 R5 sweep", t, s, durs[di]);
                end
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule